// File: doc/BRIEF.md
# Transmit Ring Low-Watermark Controller

This block keeps the bookkeeping for a circular transmit descriptor ring. A host-side producer pushes descriptors in at the write end, and a hardware consumer reports, one strobe at a time, that it has finished the oldest queued descriptor. The block holds both ring indices and the fill count. When the ring fills up, it tells the producer to stop submitting.

Interrupting on every completion would cost too much, and waiting for an empty ring would leave the consumer idle while the producer refills. So at the moment the ring becomes full, the block tags one queued descriptor, a quarter of the ring depth above the drain point. When that descriptor retires, the block raises a sticky wake interrupt and drops the stop request, and the producer can top the ring up before it runs dry. If the consumer always keeps up, the ring never fills and no wake interrupt is raised.

Control is a two-state machine:
- `ST_OPEN`: no tag is outstanding and the producer may submit.
- `ST_THROTTLE`: a tag is outstanding and stop is requested.

Two transitions move between them:
- `fill_to_full` (`ST_OPEN` to `ST_THROTTLE`): an accepted push, with no accepted completion in the same cycle, raises the fill count from DEPTH-1 to DEPTH.
- `tag_retired` (`ST_THROTTLE` to `ST_OPEN`): an accepted completion arrives while the consumer index equals the tag index.

Top module: `txwm_ring_ctrl`

## Requirements
- R1: An accepted push advances the producer index by one modulo DEPTH. An accepted completion advances the consumer index by one modulo DEPTH. `fill_cnt_o` is the number of queued descriptors, from 0 to DEPTH, and is updated at the clock edge that samples the strobes.
- R2: `queue_stop_o` is 1 from the clock edge at which the fill count reaches DEPTH (transition `fill_to_full`) until the edge at which the tagged descriptor retires. It rises again only when the ring becomes full again.
- R3: On `fill_to_full`, `tag_valid_o` becomes 1 and `tag_idx_o` becomes (consumer index + DEPTH/4) mod DEPTH. At most one tag is outstanding, and it does not move while `tag_valid_o` is 1.
- R4: In `ST_THROTTLE`, an accepted completion while the consumer index equals `tag_idx_o` causes the following at the same edge:
  - `wake_irq_o` is set.
  - `queue_stop_o` and `tag_valid_o` clear.
  - The machine returns to `ST_OPEN`.
  No other completion sets `wake_irq_o`.
- R5: `wake_irq_o` stays set until a cycle with `irq_clr_i` = 1 clears it at the next edge. If a set and a clear fall in the same cycle, the set wins.
- R6: A push sampled while the fill count is DEPTH is ignored, even with a completion in the same cycle: the producer index does not change. It sets `ovf_err_o`, which stays set until reset.
- R7: A completion strobe sampled while the fill count is 0 is ignored: the consumer index does not change.
- R8: If the consumer drains at least as fast as the producer fills, so that the count never reaches DEPTH, then `queue_stop_o` and `wake_irq_o` stay 0.
- R9: After reset the following are all 0:
  - both indices and the fill count;
  - `queue_stop_o`, `wake_irq_o`, `ovf_err_o`;
  - `tag_valid_o` and `tag_idx_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | Producer submits one descriptor |
| done_i | input | 1 | Consumer finished the oldest queued descriptor |
| irq_clr_i | input | 1 | Write-one-to-clear for the wake interrupt |
| queue_stop_o | output | 1 | Request that the producer stop submitting |
| wake_irq_o | output | 1 | Sticky wake interrupt |
| ovf_err_o | output | 1 | Sticky flag: a push arrived while the ring was full |
| prod_idx_o | output | $clog2(DEPTH) | Producer (write) index |
| cons_idx_o | output | $clog2(DEPTH) | Consumer (drain) index |
| fill_cnt_o | output | $clog2(DEPTH)+1 | Number of queued descriptors |
| tag_valid_o | output | 1 | A low-watermark tag is outstanding |
| tag_idx_o | output | $clog2(DEPTH) | Index of the tagged descriptor |

## Verification
The hardest situation to reach from the ports is a tag retiring in the same cycle as a software clear, after both indices have wrapped, with a second throttle episode following. The stimulus reaches it in stages:
- It fills the ring to full, twice over, with overflow pushes and mixed push-with-completion cycles at the full boundary.
- It drains until the bench's own model reports that the consumer sits on the tag, and drives the clear exactly in that cycle.
- A long pseudo-random phase with a push-heavy bias then revisits full, empty and tag retirement at varied indices. A behavioural model built on integers is compared against every output after every edge.

// File: rtl/txwm_pkg.sv
package txwm_pkg;
    typedef enum logic [0:0] {
        ST_OPEN     = 1'b0,
        ST_THROTTLE = 1'b1
    } wm_state_e;
endpackage

// File: rtl/txwm_ptrs.sv
module txwm_ptrs #(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic          done_i,
    output logic          push_ok_o,
    output logic          done_ok_o,
    output logic          push_rej_o,
    output logic [AW-1:0] wr_idx_o,
    output logic [AW-1:0] rd_idx_o,
    output logic [AW:0]   cnt_o
);
    // Each pointer carries one extra wrap bit so that full and empty differ.
    logic [AW:0] wr_q, rd_q;
    logic        full, empty;

    assign cnt_o      = wr_q - rd_q;
    assign full       = (cnt_o == (AW+1)'(DEPTH));
    assign empty      = (cnt_o == '0);
    assign push_ok_o  = push_i && !full;
    assign push_rej_o = push_i && full;
    assign done_ok_o  = done_i && !empty;
    assign wr_idx_o   = wr_q[AW-1:0];
    assign rd_idx_o   = rd_q[AW-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q <= '0;
            rd_q <= '0;
        end else begin
            if (push_ok_o) wr_q <= wr_q + 1'b1;
            if (done_ok_o) rd_q <= rd_q + 1'b1;
        end
    end
endmodule

// File: rtl/txwm_fsm.sv
module txwm_fsm
    import txwm_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW  = $clog2(DEPTH),
    localparam int QTR = DEPTH / 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_ok_i,
    input  logic          done_ok_i,
    input  logic [AW-1:0] rd_idx_i,
    input  logic [AW:0]   cnt_i,
    output logic          stop_o,
    output logic          tag_vld_o,
    output logic [AW-1:0] tag_idx_o,
    output logic          wake_o
);
    wm_state_e state_q, state_d;
    logic [AW-1:0] tag_q;
    logic fill_to_full, tag_retired;

    assign fill_to_full = push_ok_i && !done_ok_i && (cnt_i == (AW+1)'(DEPTH - 1));
    assign tag_retired  = done_ok_i && (rd_idx_i == tag_q);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OPEN:     if (fill_to_full) state_d = ST_THROTTLE;
            ST_THROTTLE: if (tag_retired)  state_d = ST_OPEN;
            default:     state_d = ST_OPEN;
        endcase
    end

    // state and tag registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OPEN;
            tag_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_OPEN && fill_to_full)
                tag_q <= rd_idx_i + AW'(QTR);
        end
    end

    // outputs
    always_comb begin
        stop_o    = 1'b0;
        tag_vld_o = 1'b0;
        wake_o    = 1'b0;
        unique case (state_q)
            ST_OPEN: ;
            ST_THROTTLE: begin
                stop_o    = 1'b1;
                tag_vld_o = 1'b1;
                wake_o    = tag_retired;
            end
            default: ;
        endcase
    end

    assign tag_idx_o = tag_q;
endmodule

// File: rtl/txwm_status.sv
module txwm_status (
    input  logic clk,
    input  logic rst_n,
    input  logic wake_set_i,
    input  logic wake_clr_i,
    input  logic ovf_set_i,
    output logic wake_o,
    output logic ovf_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wake_o <= 1'b0;
            ovf_o  <= 1'b0;
        end else begin
            // a set in the same cycle as a clear wins
            wake_o <= wake_set_i | (wake_o & ~wake_clr_i);
            ovf_o  <= ovf_o | ovf_set_i;
        end
    end
endmodule

// File: rtl/txwm_ring_ctrl.sv
module txwm_ring_ctrl #(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic          done_i,
    input  logic          irq_clr_i,
    output logic          queue_stop_o,
    output logic          wake_irq_o,
    output logic          ovf_err_o,
    output logic [AW-1:0] prod_idx_o,
    output logic [AW-1:0] cons_idx_o,
    output logic [AW:0]   fill_cnt_o,
    output logic          tag_valid_o,
    output logic [AW-1:0] tag_idx_o
);
    logic push_ok, done_ok, push_rej, wake_pulse;

    txwm_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (push_i),
        .done_i     (done_i),
        .push_ok_o  (push_ok),
        .done_ok_o  (done_ok),
        .push_rej_o (push_rej),
        .wr_idx_o   (prod_idx_o),
        .rd_idx_o   (cons_idx_o),
        .cnt_o      (fill_cnt_o)
    );

    txwm_fsm #(.DEPTH(DEPTH)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_ok_i (push_ok),
        .done_ok_i (done_ok),
        .rd_idx_i  (cons_idx_o),
        .cnt_i     (fill_cnt_o),
        .stop_o    (queue_stop_o),
        .tag_vld_o (tag_valid_o),
        .tag_idx_o (tag_idx_o),
        .wake_o    (wake_pulse)
    );

    txwm_status u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .wake_set_i (wake_pulse),
        .wake_clr_i (irq_clr_i),
        .ovf_set_i  (push_rej),
        .wake_o     (wake_irq_o),
        .ovf_o      (ovf_err_o)
    );
endmodule

// File: rtl/txwm_ring_ctrl_chk.sv
module txwm_ring_ctrl_chk #(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          push_i,
    input logic          done_i,
    input logic          queue_stop_o,
    input logic          wake_irq_o,
    input logic          ovf_err_o,
    input logic [AW-1:0] prod_idx_o,
    input logic [AW-1:0] cons_idx_o,
    input logic [AW:0]   fill_cnt_o,
    input logic          tag_valid_o,
    input logic [AW-1:0] tag_idx_o
);
    a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fill_cnt_o <= (AW+1)'(DEPTH));

    a_r2_stop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_cnt_o == (AW+1)'(DEPTH)) |-> queue_stop_o);

    a_r3_tag_distance: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tag_valid_o) |-> (tag_idx_o == cons_idx_o + AW'(DEPTH / 4)));

    a_r3_tag_held: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_valid_o && $past(tag_valid_o)) |-> $stable(tag_idx_o));

    a_r4_wake_on_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(queue_stop_o) |-> wake_irq_o);

    a_r4_wake_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_irq_o) |-> $fell(queue_stop_o));

    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && fill_cnt_o == (AW+1)'(DEPTH)) |=> ($stable(prod_idx_o) && ovf_err_o));

    a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_err_o |=> ovf_err_o);

    a_r7_empty_done: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && fill_cnt_o == '0) |=> $stable(cons_idx_o));
endmodule

bind txwm_ring_ctrl txwm_ring_ctrl_chk #(.DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .push_i       (push_i),
    .done_i       (done_i),
    .queue_stop_o (queue_stop_o),
    .wake_irq_o   (wake_irq_o),
    .ovf_err_o    (ovf_err_o),
    .prod_idx_o   (prod_idx_o),
    .cons_idx_o   (cons_idx_o),
    .fill_cnt_o   (fill_cnt_o),
    .tag_valid_o  (tag_valid_o),
    .tag_idx_o    (tag_idx_o)
);

// File: tb/txwm_ring_ctrl_test.sv
`timescale 1ns/1ps
module txwm_ring_ctrl_test;
    localparam int DEPTH = 64;
    localparam int AW = $clog2(DEPTH);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic push_i = 1'b0, done_i = 1'b0, irq_clr_i = 1'b0;
    logic queue_stop_o, wake_irq_o, ovf_err_o, tag_valid_o;
    logic [AW-1:0] prod_idx_o, cons_idx_o, tag_idx_o;
    logic [AW:0] fill_cnt_o;

    always #4 clk = ~clk;   // 125 MHz

    txwm_ring_ctrl #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .push_i(push_i), .done_i(done_i),
        .irq_clr_i(irq_clr_i), .queue_stop_o(queue_stop_o),
        .wake_irq_o(wake_irq_o), .ovf_err_o(ovf_err_o),
        .prod_idx_o(prod_idx_o), .cons_idx_o(cons_idx_o),
        .fill_cnt_o(fill_cnt_o), .tag_valid_o(tag_valid_o),
        .tag_idx_o(tag_idx_o)
    );

    int n_chk = 0, n_fail = 0;
    // behavioural reference
    int m_cnt = 0, m_prod = 0, m_cons = 0, m_tag = 0;
    bit m_stop = 0, m_irq = 0, m_ovf = 0, m_tagv = 0;
    bit saw_wake = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk(int'(prod_idx_o) == m_prod, "R1 producer index", int'(prod_idx_o), m_prod);
        chk(int'(cons_idx_o) == m_cons, "R1/R7 consumer index", int'(cons_idx_o), m_cons);
        chk(int'(fill_cnt_o) == m_cnt, "R1 fill count", int'(fill_cnt_o), m_cnt);
        chk(queue_stop_o == m_stop, "R2 queue stop", int'(queue_stop_o), int'(m_stop));
        chk(tag_valid_o == m_tagv, "R3 tag valid", int'(tag_valid_o), int'(m_tagv));
        if (m_tagv) chk(int'(tag_idx_o) == m_tag, "R3 tag index", int'(tag_idx_o), m_tag);
        chk(wake_irq_o == m_irq, "R4/R5 wake irq", int'(wake_irq_o), int'(m_irq));
        chk(ovf_err_o == m_ovf, "R6 overflow flag", int'(ovf_err_o), int'(m_ovf));
    endtask

    // drive at the falling edge, model the rising edge, check one unit later
    task automatic step(input bit p, input bit d, input bit c);
        bit full, acc_p, acc_d, set;
        @(negedge clk);
        push_i = p; done_i = d; irq_clr_i = c;
        @(posedge clk);
        #1;
        full  = (m_cnt == DEPTH);
        acc_p = p && !full;
        acc_d = d && (m_cnt != 0);
        if (p && full) m_ovf = 1;
        set = 0;
        if (m_stop && acc_d && m_cons == m_tag) begin
            set = 1; m_stop = 0; m_tagv = 0;
        end else if (!m_stop && acc_p && !acc_d && m_cnt == DEPTH - 1) begin
            m_stop = 1; m_tagv = 1; m_tag = (m_cons + DEPTH / 4) % DEPTH;
        end
        m_irq = set ? 1'b1 : (m_irq && !c);
        if (set) saw_wake = 1;
        if (acc_p) begin m_prod = (m_prod + 1) % DEPTH; m_cnt++; end
        if (acc_d) begin m_cons = (m_cons + 1) % DEPTH; m_cnt--; end
        compare_all();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        logic [15:0] lfsr;
        lfsr = 16'hACE1;
        repeat (3) @(posedge clk);
        #1;
        // R9: reset values
        compare_all();
        chk(queue_stop_o == 0 && wake_irq_o == 0 && tag_idx_o == 0, "R9 reset state",
            int'(queue_stop_o) + int'(wake_irq_o), 0);
        @(negedge clk) rst_n = 1'b1;

        // R7: completions on an empty ring are ignored
        repeat (3) step(0, 1, 0);

        // R8: consumer keeps up, the ring never fills
        for (int i = 0; i < 150; i++) begin
            step(1, (i % 3) == 2, 0);
            step(0, 1, 0);
            if (i % 5 == 0) step(1, 1, 0);
        end
        chk(!saw_wake && !m_stop, "R8 no watermark without full", int'(saw_wake), 0);

        // R2/R3: fill to full
        while (m_cnt < DEPTH) step(1, 0, 0);
        // R6: overflow pushes, including one paired with a completion
        step(1, 0, 0);
        step(1, 0, 0);
        step(1, 1, 0);
        step(1, 0, 0);   // R6: DEPTH-1 queued now; this push refills, tag unchanged

        // R5: clear while nothing set, then drain; clear in the tag cycle
        step(0, 0, 1);
        while (m_stop) begin
            if (m_cons == m_tag) step(0, 1, 1);   // R5: set wins over clear
            else step(0, 1, 0);
        end
        step(0, 0, 0);
        step(0, 0, 1);   // R5: clear
        step(0, 0, 0);

        // second episode after wrap: refill with pushes while throttled
        while (m_cnt < DEPTH) step(1, 0, 0);
        while (m_stop) step(m_cnt < DEPTH - 2, 1, 0);
        while (m_cnt > 0) step(0, 1, 0);
        step(0, 0, 1);

        // mixed pseudo-random traffic, push-heavy
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[1:0] != 2'b00, lfsr[3:2] == 2'b11 || (i % 700) > 500,
                 lfsr[7:4] == 4'h0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule